// File: doc/BRIEF.md
# XOR-Encoded Multi-Port Register File

This block is a register file with four write ports and eight read ports over one shared address space. Its only storage element is a simple memory with a single write port and a single registered read port. Each write port owns a bank of such memories. Every memory in a bank receives the same write traffic, and each one serves exactly one reader. Eight copies serve the external read ports. The other three copies serve the early reads made by the other write ports.

A bank never holds plain data. When a write is accepted, its first pipeline stage reads the target address from every other write port's bank. In the second stage it stores the new data XORed with those values into its own bank. A logical read XORs the word at the requested address from all four banks, and the terms cancel so that the newest value is left. A write that has been committed to its bank memories in the cycle just before a read is not yet visible in those memories. A small forwarding register per bank holds the value that was committed last. Reads and early write reads use it in place of the stale memory word when its address matches.

Top module: `xrf_regfile`

## Requirements
- R1: Each of the eight read ports returns, one clock after its address is presented, the value of the newest write to that address that was presented in an earlier cycle.
- R2: A write presented in cycle t is seen by reads presented in cycle t+1 and later. A read presented in cycle t itself returns the value from before that write.
- R3: After reset every location reads as zero until it is first written, and all read outputs are zero in the first cycle after reset.
- R4: Writes on several ports in one cycle to distinct addresses all take effect. Two enabled write ports with the same address in one cycle are illegal, are flagged by the checker, and leave the stored result undefined.
- R5: When different write ports write one address in consecutive cycles, the later write wins. This holds for a read issued in the cycle right after the later write.
- R6: When one write port writes the same address in consecutive cycles, the later write wins.
- R7: Read ports are independent. All eight may read one address, or eight different addresses, in the same cycle.
- R8: A write port with its enable low changes no location, whatever its address and data inputs carry.
- R9: A write changes only its own address. Every other location keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears all banks |
| wr_en | input | NW | Write enable, one bit per write port |
| wr_addr | input | NW*AW | Write address per write port |
| wr_data | input | NW*DW | Write data per write port |
| rd_addr | input | NR*AW | Read address per read port |
| rd_data | output | NR*DW | Read data per read port, valid one clock after the address |

## Verification
The functions that collide are the late store of a write and either a read or another port's early read of the same address in the next cycle. In that cycle the bank memories still hold the old word, so the result is correct only if forwarding substitutes it. The bench provokes this in three ways: reading an address in the cycle right after it is written, chaining writes from all four ports to one address in consecutive cycles, and repeating writes from one port. It also sends random traffic in which four read ports always read the addresses written one cycle earlier. A behavioural array model judges every read port on every cycle. The model applies writes in presentation order, and each read sees the array as it stood before the writes of its own cycle.

// File: rtl/xrf_pkg.sv
package xrf_pkg;
    // Copy index, inside bank `bank`, of the memory that serves write port
    // `reader`'s early read. Copies 0..nr-1 serve the external read ports.
    function automatic int xrf_slot(input int nr, input int bank, input int reader);
        return nr + ((reader < bank) ? reader : reader - 1);
    endfunction

    // Write port whose early read is served by internal copy k of bank `bank`.
    function automatic int xrf_other(input int bank, input int k);
        return (k < bank) ? k : k + 1;
    endfunction
endpackage

// File: rtl/xrf_sram.sv
module xrf_sram #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd
);
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rd_d, rd_q;

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[wa] = wd;
        rd_d = mem_q[ra];           // read returns the word before this edge's write
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
            rd_q  <= '0;
        end else begin
            mem_q <= mem_d;
            rd_q  <= rd_d;
        end
    end

    assign rd = rd_q;
endmodule

// File: rtl/xrf_bank.sv
module xrf_bank #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    parameter int NCOPY = 11,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              wa,
    input  logic [DW-1:0]              wd,
    input  logic [NCOPY-1:0][AW-1:0]   ra,
    output logic [NCOPY-1:0][DW-1:0]   rd
);
    // Every copy sees the same write; each copy has its own single reader.
    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        xrf_sram #(.DW(DW), .DEPTH(DEPTH)) u_mem (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (we),
            .wa   (wa),
            .wd   (wd),
            .ra   (ra[c]),
            .rd   (rd[c])
        );
    end
endmodule

// File: rtl/xrf_rdfold.sv
module xrf_rdfold #(
    parameter int NW = 4,
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic [NW-1:0][DW-1:0] bank_word,
    input  logic [NW-1:0]         incl,
    input  logic [AW-1:0]         addr,
    input  logic [NW-1:0]         fw_vld,
    input  logic [NW-1:0][AW-1:0] fw_addr,
    input  logic [NW-1:0][DW-1:0] fw_word,
    output logic [DW-1:0]         value
);
    // XOR the selected banks. A bank whose last commit hit this address
    // contributes the committed word instead of its stale memory output.
    always_comb begin
        value = '0;
        for (int v = 0; v < NW; v++) begin
            if (incl[v]) begin
                if (fw_vld[v] && (fw_addr[v] == addr)) value = value ^ fw_word[v];
                else                                   value = value ^ bank_word[v];
            end
        end
    end
endmodule

// File: rtl/xrf_regfile.sv
module xrf_regfile
    import xrf_pkg::*;
#(
    parameter int NW    = 4,
    parameter int NR    = 8,
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NW-1:0]         wr_en,
    input  logic [NW-1:0][AW-1:0] wr_addr,
    input  logic [NW-1:0][DW-1:0] wr_data,
    input  logic [NR-1:0][AW-1:0] rd_addr,
    output logic [NR-1:0][DW-1:0] rd_data
);
    localparam int NCOPY = NR + NW - 1;

    typedef struct packed {
        logic [NW-1:0]         s2_vld;   // write stage 2: encode and store
        logic [NW-1:0][AW-1:0] s2_addr;
        logic [NW-1:0][DW-1:0] s2_data;
        logic [NW-1:0]         s3_vld;   // word committed at the last edge
        logic [NW-1:0][AW-1:0] s3_addr;
        logic [NW-1:0][DW-1:0] s3_enc;
        logic [NR-1:0][AW-1:0] rd_addr;  // external read address in flight
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [NCOPY-1:0][AW-1:0] bank_ra [NW];
    logic [NCOPY-1:0][DW-1:0] bank_rd [NW];
    logic [NW-1:0][DW-1:0]    rfold_word [NR];
    logic [NW-1:0][DW-1:0]    wfold_word [NW];
    logic [NW-1:0][DW-1:0]    wsum;
    logic [NW-1:0][DW-1:0]    enc;

    // Read address routing: external copies follow the read ports, internal
    // copies follow the write ports that must read this bank early.
    always_comb begin
        for (int v = 0; v < NW; v++) begin
            for (int r = 0; r < NR; r++) bank_ra[v][r] = rd_addr[r];
            for (int k = 0; k < NW - 1; k++) bank_ra[v][NR + k] = wr_addr[xrf_other(v, k)];
        end
    end

    // Gather the words each fold needs.
    always_comb begin
        for (int r = 0; r < NR; r++)
            for (int v = 0; v < NW; v++)
                rfold_word[r][v] = bank_rd[v][r];
        for (int w = 0; w < NW; w++)
            for (int v = 0; v < NW; v++)
                wfold_word[w][v] = (v == w) ? '0 : bank_rd[v][xrf_slot(NR, v, w)];
    end

    for (genvar v = 0; v < NW; v++) begin : g_bank
        xrf_bank #(.DW(DW), .DEPTH(DEPTH), .NCOPY(NCOPY)) u_bank (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (pipe_q.s2_vld[v]),
            .wa   (pipe_q.s2_addr[v]),
            .wd   (enc[v]),
            .ra   (bank_ra[v]),
            .rd   (bank_rd[v])
        );
    end

    for (genvar w = 0; w < NW; w++) begin : g_wfold
        localparam logic [NW-1:0] OTHERS = ~(NW'(1) << w);
        xrf_rdfold #(.NW(NW), .DW(DW), .AW(AW)) u_fold (
            .bank_word(wfold_word[w]),
            .incl     (OTHERS),
            .addr     (pipe_q.s2_addr[w]),
            .fw_vld   (pipe_q.s3_vld),
            .fw_addr  (pipe_q.s3_addr),
            .fw_word  (pipe_q.s3_enc),
            .value    (wsum[w])
        );
        assign enc[w] = pipe_q.s2_data[w] ^ wsum[w];
    end

    for (genvar r = 0; r < NR; r++) begin : g_rfold
        xrf_rdfold #(.NW(NW), .DW(DW), .AW(AW)) u_fold (
            .bank_word(rfold_word[r]),
            .incl     ({NW{1'b1}}),
            .addr     (pipe_q.rd_addr[r]),
            .fw_vld   (pipe_q.s3_vld),
            .fw_addr  (pipe_q.s3_addr),
            .fw_word  (pipe_q.s3_enc),
            .value    (rd_data[r])
        );
    end

    always_comb begin
        pipe_d         = pipe_q;
        pipe_d.s2_vld  = wr_en;
        pipe_d.s2_addr = wr_addr;
        pipe_d.s2_data = wr_data;
        pipe_d.s3_vld  = pipe_q.s2_vld;
        pipe_d.s3_addr = pipe_q.s2_addr;
        pipe_d.s3_enc  = enc;
        pipe_d.rd_addr = rd_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end
endmodule

// File: rtl/xrf_regfile_chk.sv
module xrf_regfile_chk #(
    parameter int NW    = 4,
    parameter int NR    = 8,
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NW-1:0]         wr_en,
    input logic [NW-1:0][AW-1:0] wr_addr,
    input logic [NW-1:0][DW-1:0] wr_data,
    input logic [NR-1:0][AW-1:0] rd_addr,
    input logic [NR-1:0][DW-1:0] rd_data
);
    logic [DW-1:0]         sh_q [DEPTH];
    logic [NR-1:0][DW-1:0] exp_q;
    logic [1:0]            cyc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '{default: '0};
            exp_q <= '0;
            cyc_q <= '0;
        end else begin
            for (int r = 0; r < NR; r++) exp_q[r] <= sh_q[rd_addr[r]];
            for (int w = 0; w < NW; w++) if (wr_en[w]) sh_q[wr_addr[w]] <= wr_data[w];
            if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
        end
    end

    for (genvar r = 0; r < NR; r++) begin : g_rd
        // R1, R9: each read port tracks a plain array of the written words
        assert_read_matches_R1: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[r] == exp_q[r]);
        assert_zero_after_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc_q == 2'd0) |-> (rd_data[r] == '0));
        for (genvar w = 0; w < NW; w++) begin : g_fw
            assert_fresh_write_seen_R2: assert property (@(posedge clk) disable iff (!rst_n)
                ((cyc_q >= 2'd2) && $past(wr_en[w], 2) &&
                 ($past(rd_addr[r], 1) == $past(wr_addr[w], 2)))
                |-> (rd_data[r] == $past(wr_data[w], 2)));
        end
    end

    for (genvar i = 0; i < NW; i++) begin : g_ci
        for (genvar j = i + 1; j < NW; j++) begin : g_cj
            assert_no_write_collision_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en[i] && wr_en[j] && (wr_addr[i] == wr_addr[j])));
        end
    end
endmodule

bind xrf_regfile xrf_regfile_chk #(.NW(NW), .NR(NR), .DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
);

// File: tb/xrf_regfile_tb.sv
module xrf_regfile_tb;
    localparam int NW = 4, NR = 8, DW = 32, DEPTH = 32;
    localparam int AW = $clog2(DEPTH);

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NW-1:0]         wr_en = '0;
    logic [NW-1:0][AW-1:0] wr_addr = '0;
    logic [NW-1:0][DW-1:0] wr_data = '0;
    logic [NR-1:0][AW-1:0] rd_addr = '0;
    logic [NR-1:0][DW-1:0] rd_data;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] nexp [NR];

    always #4 clk = ~clk;

    xrf_regfile #(.NW(NW), .NR(NR), .DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

    task automatic check(input int r, input logic [DW-1:0] exp, input string tag);
        total++;
        if (rd_data[r] !== exp) begin
            bad++;
            $display("FAIL %s port %0d got %h exp %h", tag, r, rd_data[r], exp);
        end
    endtask

    // One cycle: drive at the falling edge, update the model, check the result
    // at the next falling edge (one register stage later).
    task automatic step(input string tag);
        for (int r = 0; r < NR; r++) nexp[r] = ref_mem[rd_addr[r]];
        for (int w = 0; w < NW; w++) if (wr_en[w]) ref_mem[wr_addr[w]] = wr_data[w];
        @(negedge clk);
        for (int r = 0; r < NR; r++) check(r, nexp[r], tag);
    endtask

    task automatic idle();
        wr_en = '0;
    endtask

    task automatic read_all(input int base);
        for (int r = 0; r < NR; r++) rd_addr[r] = AW'(base + r);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) ref_mem[a] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int r = 0; r < NR; r++) check(r, '0, "R3 first cycle");

        // R3: whole array reads zero after reset
        for (int b = 0; b < DEPTH; b += NR) begin read_all(b); step("R3"); end

        // R1/R4: four ports write distinct addresses in one cycle
        wr_en = '1;
        for (int w = 0; w < NW; w++) begin
            wr_addr[w] = AW'(w + 1); wr_data[w] = 32'hA5A5_0000 + DW'(w);
        end
        read_all(0); step("R4 write cycle");
        idle(); read_all(0); step("R4");
        read_all(1); step("R1");

        // R7: all read ports on one address, then spread
        for (int r = 0; r < NR; r++) rd_addr[r] = AW'(3);
        step("R7 same");
        for (int r = 0; r < NR; r++) rd_addr[r] = AW'(NR - 1 - r);
        step("R7 spread");

        // R2: read in the write cycle returns old, next cycle new
        wr_en = 4'b0010; wr_addr[1] = AW'(12); wr_data[1] = 32'h1234_5678;
        for (int r = 0; r < NR; r++) rd_addr[r] = AW'(12);
        step("R2 same cycle");
        idle(); step("R2 next cycle");
        step("R2 settled");

        // R5: chain of ports 0..3 on one address, read every cycle
        for (int r = 0; r < NR; r++) rd_addr[r] = AW'(9);
        for (int w = 0; w < NW; w++) begin
            wr_en = '0; wr_en[w] = 1'b1;
            wr_addr[w] = AW'(9); wr_data[w] = 32'hC0DE_0000 + DW'(w * 17);
            step("R5");
        end
        idle(); step("R5"); step("R5");

        // R6: one port repeats writes to one address
        for (int r = 0; r < NR; r++) rd_addr[r] = AW'(7);
        for (int k = 0; k < 3; k++) begin
            wr_en = 4'b0100; wr_addr[2] = AW'(7); wr_data[2] = 32'hBEEF_0000 + DW'(k);
            step("R6");
        end
        idle(); step("R6"); step("R6");

        // R8: enable low, address and data carry junk
        wr_en = '0;
        for (int w = 0; w < NW; w++) begin wr_addr[w] = AW'(3); wr_data[w] = 32'hDEAD_DEAD; end
        for (int r = 0; r < NR; r++) rd_addr[r] = AW'(3);
        step("R8"); step("R8"); step("R8");

        // R9: random traffic, four read ports follow last cycle's write addresses
        for (int c = 0; c < 3000; c++) begin
            logic [NW-1:0][AW-1:0] prev = wr_addr;
            for (int w = 0; w < NW; w++) begin
                wr_en[w]   = ($urandom % 4) != 0;
                wr_addr[w] = AW'($urandom % DEPTH);
                wr_data[w] = $urandom;
                for (int u = 0; u < w; u++)
                    if (wr_en[u] && wr_en[w] && wr_addr[u] == wr_addr[w]) wr_en[w] = 1'b0;
            end
            for (int r = 0; r < NR; r++)
                rd_addr[r] = (r < NW) ? prev[r] : AW'($urandom % DEPTH);
            step("R9");
        end
        idle();
        for (int b = 0; b < DEPTH; b += NR) begin read_all(b); step("R9 sweep"); end
        summary();
    end
endmodule